// File: doc/BRIEF.md
# Operator-Injectable Data Memory

This block is the word-addressed data store of a small single-cycle processor, with a second writer attached: a manual operator panel. The processor sees an ordinary memory. It has a byte address, write data, a write enable, and a read port that answers in the same cycle. The panel holds a pending entry word, which it loads from a value input. A rising edge on a commit input copies that pending word into one of two fixed input slots. A one-bit selector picks the slot: byte address 0x0 or 0x4. Two fixed result slots, at byte addresses 0x8 and 0xC, are driven out all the time so that a display can show them.

The processor and the panel can both write in the same clock cycle. When they do, the panel write is kept and the processor write is discarded. A separate panel reset clears the pending entry and its commit history. It never changes the stored words. The main reset clears every word.

All pins are plain level signals with no valid/ready handshake. A panel commit is a single event taken on its edge. The processor port is a single-cycle access, so neither side ever has to wait.

Top module: `opdm_top`

## Requirements
- R1: While `rst_n` is low, every memory word is cleared to zero. After reset, reads and both display outputs return zero.
- R2: When `cpu_we` is high, the word at index `cpu_addr[IDX_W+1:2]` takes `cpu_wdata` on the clock edge. `cpu_rdata` shows the word at that index in the same cycle. Address bits 1:0 have no effect.
- R3: Address bits above `IDX_W+1` are ignored. With the default depth of 64 words, byte address 0x100 reaches the same word as 0x0.
- R4: On a clock edge where `op_load` is high, the pending entry register takes `op_value`.
- R5: A commit edge is a cycle in which `op_commit` is high after being low in the previous cycle. On a commit edge, the pending entry is written to word 0 (byte 0x0) if `op_sel` is 0, or to word 1 (byte 0x4) if `op_sel` is 1.
- R6: Holding `op_commit` high writes exactly once. Values loaded while it stays high are not written until the next commit edge.
- R7: If a commit edge and `cpu_we` fall in the same cycle, the operator write is performed. The processor write is dropped entirely, whether it targets the same word or a different one.
- R8: `show_lo` always equals the word at byte 0x8 (word 2), and `show_hi` the word at byte 0xC (word 3). Both reflect a write from the cycle after its clock edge.
- R9: While `panel_rst_n` is low, the pending entry is cleared to zero, commit history is set to "already high", and no operator write occurs. Memory contents are not changed. A commit held across a panel reset therefore does not write.
- R10: When a commit edge and `op_load` occur in the same cycle, the value written is the pending entry from before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all memory words |
| cpu_addr | input | ADDR_W | Processor byte address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_we | input | 1 | Processor write enable |
| cpu_rdata | output | DATA_W | Combinational read of addressed word |
| op_value | input | DATA_W | Operator entry value |
| op_load | input | 1 | Capture `op_value` into the pending entry |
| op_sel | input | 1 | Destination slot select (0: byte 0x0, 1: byte 0x4) |
| op_commit | input | 1 | Commit request, acted on at its rising edge |
| panel_rst_n | input | 1 | Active-low panel reset, clears pending entry only |
| show_lo | output | DATA_W | Word at byte address 0x8 |
| show_hi | output | DATA_W | Word at byte address 0xC |

## Verification
A processor store and an operator commit edge can land on the same clock edge. The bench provokes this twice. In the first case the processor targets a different word from the operator. In the second both target the same input slot. The outcome is judged by reading back both words through the processor port. The operator value must be present, and the processor's target word must keep its earlier content. In the same-slot case, the operator value must have replaced the processor data. Other checks cover a held commit, a commit that coincides with a load, and a panel reset with commit held high.

// File: rtl/opdm_pkg.sv
package opdm_pkg;
  // word slots with fixed meaning (byte address = 4 * word)
  localparam int SLOT_IN0  = 0;
  localparam int SLOT_IN1  = 1;
  localparam int SLOT_OUT0 = 2;
  localparam int SLOT_OUT1 = 3;
  localparam int SLOT_MIN_DEPTH = 4;
endpackage

// File: rtl/opdm_entry.sv
module opdm_entry #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              panel_rst_n,
  input  logic [DATA_W-1:0] op_value,
  input  logic              op_load,
  input  logic              op_commit,
  output logic              op_we,
  output logic [DATA_W-1:0] op_wdata
);
  logic [DATA_W-1:0] pend_q;
  logic              seen_q;

  // seen_q starts high so a commit held through either reset never fires
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      seen_q <= 1'b1;
    end else if (!panel_rst_n) begin
      pend_q <= '0;
      seen_q <= 1'b1;
    end else begin
      if (op_load) pend_q <= op_value;
      seen_q <= op_commit;
    end
  end

  assign op_we    = panel_rst_n && op_commit && !seen_q;
  assign op_wdata = pend_q;

  assert_single_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op_we |=> !op_we);

  assert_panel_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !panel_rst_n |=> (pend_q == '0));

  assert_panel_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !panel_rst_n |-> !op_we);

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (panel_rst_n && op_load) |=> (pend_q == $past(op_value)));
endmodule

// File: rtl/opdm_store.sv
module opdm_store
  import opdm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [IDX_W-1:0]  cpu_idx,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              op_we,
  input  logic [IDX_W-1:0]  op_idx,
  input  logic [DATA_W-1:0] op_wdata,
  output logic [DATA_W-1:0] show_lo,
  output logic [DATA_W-1:0] show_hi
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  hit_op;
  logic [DEPTH-1:0]  hit_cpu;

  // per-word enables; operator path masks the processor path entirely
  for (genvar w = 0; w < DEPTH; w++) begin : g_en
    assign hit_op[w]  = op_we && (op_idx == IDX_W'(w));
    assign hit_cpu[w] = cpu_we && !op_we && (cpu_idx == IDX_W'(w));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
    end else begin
      for (int w = 0; w < DEPTH; w++) begin
        if (hit_op[w])       mem[w] <= op_wdata;
        else if (hit_cpu[w]) mem[w] <= cpu_wdata;
      end
    end
  end

  assign cpu_rdata = mem[cpu_idx];
  assign show_lo   = mem[SLOT_OUT0];
  assign show_hi   = mem[SLOT_OUT1];

  assert_op_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    op_we |=> (mem[$past(op_idx)] == $past(op_wdata)));

  assert_cpu_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && !op_we) |=> (mem[$past(cpu_idx)] == $past(cpu_wdata)));

  assert_cpu_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && op_we && (cpu_idx != op_idx)) |=>
      (mem[$past(cpu_idx)] == $past(mem[cpu_idx])));
endmodule

// File: rtl/opdm_top.sv
module opdm_top
  import opdm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_we,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic [DATA_W-1:0] op_value,
  input  logic              op_load,
  input  logic              op_sel,
  input  logic              op_commit,
  input  logic              panel_rst_n,
  output logic [DATA_W-1:0] show_lo,
  output logic [DATA_W-1:0] show_hi
);
  logic [IDX_W-1:0]  cpu_idx;
  logic [IDX_W-1:0]  op_idx;
  logic              op_we;
  logic [DATA_W-1:0] op_wdata;
  logic              unused_addr;

  // byte address to word index; byte lane and upper bits are discarded
  assign cpu_idx     = cpu_addr[IDX_W+1:2];
  assign unused_addr = ^{cpu_addr[ADDR_W-1:IDX_W+2], cpu_addr[1:0]};
  assign op_idx      = op_sel ? IDX_W'(SLOT_IN1) : IDX_W'(SLOT_IN0);

  opdm_entry #(.DATA_W(DATA_W)) u_entry (
    .clk        (clk),
    .rst_n      (rst_n),
    .panel_rst_n(panel_rst_n),
    .op_value   (op_value),
    .op_load    (op_load),
    .op_commit  (op_commit),
    .op_we      (op_we),
    .op_wdata   (op_wdata)
  );

  opdm_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_we   (cpu_we),
    .cpu_idx  (cpu_idx),
    .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata),
    .op_we    (op_we),
    .op_idx   (op_idx),
    .op_wdata (op_wdata),
    .show_lo  (show_lo),
    .show_hi  (show_hi)
  );

  initial begin
    assert_depth_R3: assert (DEPTH >= SLOT_MIN_DEPTH && IDX_W + 2 < ADDR_W);
  end

  assert_panel_keeps_mem_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!panel_rst_n && !cpu_we) |=> ($stable(show_lo) && $stable(show_hi)));
endmodule

// File: tb/opdm_top_tb.sv
module opdm_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cpu_addr;
  logic [31:0] cpu_wdata;
  logic        cpu_we;
  logic [31:0] cpu_rdata;
  logic [31:0] op_value;
  logic        op_load;
  logic        op_sel;
  logic        op_commit;
  logic        panel_rst_n;
  logic [31:0] show_lo;
  logic [31:0] show_hi;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  opdm_top u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .cpu_rdata(cpu_rdata), .op_value(op_value),
    .op_load(op_load), .op_sel(op_sel), .op_commit(op_commit),
    .panel_rst_n(panel_rst_n), .show_lo(show_lo), .show_hi(show_hi)
  );

  typedef struct packed {
    logic        we;
    logic [31:0] waddr;
    logic [31:0] wdata;
    logic [31:0] raddr;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h10,  32'hAAAA0001, 32'h10, 32'hAAAA0001},
    '{1'b1, 32'h14,  32'hAAAA0002, 32'h14, 32'hAAAA0002},
    '{1'b1, 32'h13,  32'hAAAA0003, 32'h10, 32'hAAAA0003},
    '{1'b1, 32'h100, 32'hAAAA0004, 32'h00, 32'hAAAA0004},
    '{1'b0, 32'h14,  32'hFFFFFFFF, 32'h14, 32'hAAAA0002},
    '{1'b1, 32'h08,  32'hAAAA0006, 32'h08, 32'hAAAA0006}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic peek(input string req, input logic [31:0] addr, input logic [31:0] exp);
    cpu_we   = 1'b0;
    cpu_addr = addr;
    #1;
    check(req, cpu_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; panel_rst_n = 1'b1;
    cpu_addr = '0; cpu_wdata = '0; cpu_we = 1'b0;
    op_value = '0; op_load = 1'b0; op_sel = 1'b0; op_commit = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    peek("R1 word0", 32'h0, 32'h0);
    peek("R1 word1", 32'h4, 32'h0);
    check("R1 show_lo", show_lo, 32'h0);
    check("R1 show_hi", show_hi, 32'h0);

    // R2 / R3 processor writes from the vector table
    for (int i = 0; i < NV; i++) begin
      cpu_we = VECS[i].we; cpu_addr = VECS[i].waddr; cpu_wdata = VECS[i].wdata;
      tick();
      peek($sformatf("R2 R3 vector %0d", i), VECS[i].raddr, VECS[i].exp);
    end
    check("R8 show_lo after cpu write", show_lo, 32'hAAAA0006);

    // R4 R5 commit to slot 0
    op_value = 32'h11111111; op_load = 1'b1; tick();
    op_load = 1'b0; op_sel = 1'b0; op_commit = 1'b1; tick();
    op_commit = 1'b0;
    peek("R5 sel0 to 0x0", 32'h0, 32'h11111111);
    tick();

    // R5 commit to slot 1
    op_value = 32'h22222222; op_load = 1'b1; tick();
    op_load = 1'b0; op_sel = 1'b1; op_commit = 1'b1; tick();
    op_commit = 1'b0;
    peek("R5 sel1 to 0x4", 32'h4, 32'h22222222);
    peek("R5 slot0 untouched", 32'h0, 32'h11111111);
    tick();

    // R6 held commit writes once
    op_value = 32'h33333333; op_load = 1'b1; tick();
    op_load = 1'b0; op_commit = 1'b1; tick();
    peek("R6 first write", 32'h4, 32'h33333333);
    op_value = 32'h44444444; op_load = 1'b1; tick();
    op_load = 1'b0; tick(); tick();
    peek("R6 held commit no rewrite", 32'h4, 32'h33333333);
    op_commit = 1'b0; tick();

    // R10 load and commit in the same cycle use the older pending value
    op_value = 32'h55555555; op_load = 1'b1; op_sel = 1'b0; op_commit = 1'b1; tick();
    op_load = 1'b0; op_commit = 1'b0;
    peek("R10 old pending written", 32'h0, 32'h44444444);
    tick();

    // R7 collision, different words
    op_sel = 1'b0; op_commit = 1'b1;
    cpu_we = 1'b1; cpu_addr = 32'h14; cpu_wdata = 32'h77777777;
    tick();
    op_commit = 1'b0;
    peek("R7 operator word", 32'h0, 32'h55555555);
    peek("R7 cpu write dropped", 32'h14, 32'hAAAA0002);
    tick();

    // R7 collision, same word
    op_value = 32'h66666666; op_load = 1'b1; tick();
    op_load = 1'b0; op_sel = 1'b1; op_commit = 1'b1;
    cpu_we = 1'b1; cpu_addr = 32'h4; cpu_wdata = 32'h88888888;
    tick();
    op_commit = 1'b0;
    peek("R7 same word operator wins", 32'h4, 32'h66666666);
    tick();

    // R8 high display word
    cpu_we = 1'b1; cpu_addr = 32'hC; cpu_wdata = 32'hC0DE0003; tick();
    cpu_we = 1'b0;
    check("R8 show_hi", show_hi, 32'hC0DE0003);
    check("R8 show_lo kept", show_lo, 32'hAAAA0006);

    // R9 panel reset with commit held
    op_value = 32'h99999999; op_load = 1'b1; op_sel = 1'b0; tick();
    op_load = 1'b0; op_commit = 1'b1; panel_rst_n = 1'b0; tick();
    panel_rst_n = 1'b1; tick();
    peek("R9 held commit across panel reset", 32'h0, 32'h55555555);
    check("R9 show_lo unchanged", show_lo, 32'hAAAA0006);
    check("R9 show_hi unchanged", show_hi, 32'hC0DE0003);
    op_commit = 1'b0; tick();
    op_commit = 1'b1; tick();
    op_commit = 1'b0;
    peek("R9 pending cleared", 32'h0, 32'h0);
    peek("R9 other word kept", 32'h10, 32'hAAAA0003);
    tick();

    // R1 reset again clears everything
    rst_n = 1'b0; tick();
    rst_n = 1'b1; tick();
    peek("R1 word4 cleared", 32'h10, 32'h0);
    peek("R1 word1 cleared", 32'h4, 32'h0);
    check("R1 show_hi cleared", show_hi, 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule